// File: doc/BRIEF.md
# Error Status Interrupt Aggregator

This block keeps the error flags of three sub-units (address translation, message handling and DMA control) and reduces them to one level interrupt request for the interrupt routing logic. Hardware error pulses set flags that stay set until software clears them. Software can also force flags on, which is useful for testing the interrupt path, and it can mask interrupts per bit and per sub-unit.

All registers are reached through one single-cycle write port and a combinational read port. The address splits into a sub-unit index in the upper bits and a register select in the two lower bits. Index 0 is the translation unit, 1 the message unit, 2 the DMA control unit, and index 3 holds the group mask. Within a sub-unit, select 0 is the status view, 1 the force register, 2 the write-one-to-clear port and 3 the per-bit enable. The group mask sits at address 0xC, and its bit i belongs to sub-unit i.

Top module: `err_status_irq_agg`

## Requirements
- R1: After reset every register reads zero: flags, force, enable and group mask. `irq_req` is low.
- R2: A one on a bit of `hw_err` latches that sub-unit's flag, and the flag stays set over later cycles without further pulses. `hw_err` bits [8u+7:8u] belong to sub-unit u.
- R3: A write of ones to a sub-unit's clear register (select 2) drops the latched flags at those bit positions. Bits written as zero are left as they are. A hardware pulse on the same bit in the same cycle wins, and the flag stays set.
- R4: Writing the force register (select 1) makes the status view (select 0) read the latched flags ORed with the force bits. Writing zero to the force register removes that forcing.
- R5: A clear write does not remove a bit that is still forced. That bit keeps reading as set in the status view.
- R6: A status bit adds to its sub-unit's request only when the matching bit of that sub-unit's enable register (select 3) is one.
- R7: While bit u of the group mask (address 0xC) is zero, no flag of sub-unit u raises `irq_req`. Re-enabling one group while another stays masked lets only the enabled group's flags through.
- R8: `irq_req` is the OR of all enabled and group-enabled status bits, registered once. It changes one clock after the state that causes it.
- R9: Writes to the status view, to unused addresses and to unused bits have no effect. The clear register and unused addresses read zero.
- R10: A write to one sub-unit leaves the registers of the other sub-units unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe, acts on the rising clock edge |
| reg_addr | input | 4 | Register address: sub-unit index in [3:2], register select in [1:0] |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| hw_err | input | 24 | Hardware error pulses, 8 bits per sub-unit |
| irq_req | output | 1 | Aggregated level interrupt request |

## Verification
The masking path is driven with a flag that is enabled at both levels, a flag that has its bit enable off, a forced flag that is masked at the group level, and a latched flag that is masked while another group is open. Each case alone shows whether the per-bit gate, the group gate or their combination is at fault. Forcing is exercised against clearing, so that a clear leaving a forced bit set can be told apart from a force that wrongly latches. A pulse that coincides with a clear shows the set-over-clear priority. A single pulse followed by two samples of `irq_req` shows the one-cycle register stage.

// File: rtl/err_agg_pkg.sv
package err_agg_pkg;

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_FORCE  = 2'd1,
      SEL_CLEAR  = 2'd2,
      SEL_ENABLE = 2'd3
   } reg_sel_e;

   localparam int SEL_BITS = 2;

endpackage

// File: rtl/err_unit.sv
module err_unit
   import err_agg_pkg::*;
#(
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  reg_sel_e          sel_i,
   input  logic [STAT_W-1:0] wdata_i,
   input  logic [STAT_W-1:0] hw_err_i,
   output logic [STAT_W-1:0] view_o,
   output logic [STAT_W-1:0] force_o,
   output logic [STAT_W-1:0] enable_o,
   output logic              req_o
);

   logic [STAT_W-1:0] latched_q;
   logic [STAT_W-1:0] force_q;
   logic [STAT_W-1:0] enable_q;
   logic [STAT_W-1:0] clr_mask;

   assign clr_mask = (wr_i && sel_i == SEL_CLEAR) ? wdata_i : '0;

   for (genvar b = 0; b < STAT_W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            latched_q[b] <= 1'b0;
         else if (hw_err_i[b])
            latched_q[b] <= 1'b1;
         else if (clr_mask[b])
            latched_q[b] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         force_q  <= '0;
         enable_q <= '0;
      end else if (wr_i) begin
         if (sel_i == SEL_FORCE)  force_q  <= wdata_i;
         if (sel_i == SEL_ENABLE) enable_q <= wdata_i;
      end
   end

   assign view_o   = latched_q | force_q;
   assign force_o  = force_q;
   assign enable_o = enable_q;
   assign req_o    = |(view_o & enable_q);

   // R2
   sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask == '0) |=> ((latched_q & $past(latched_q | hw_err_i)) == $past(latched_q | hw_err_i)));

   // R3
   w1c_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask != '0) |=> ((latched_q & $past(clr_mask & ~hw_err_i)) == '0));

   // R5
   force_survives_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel_i == SEL_CLEAR) |=> ((view_o & $past(force_q)) == $past(force_q)));

endmodule

// File: rtl/err_group_gate.sv
module err_group_gate #(
   parameter int NUM_UNITS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 grp_wr_i,
   input  logic [NUM_UNITS-1:0] grp_wdata_i,
   input  logic [NUM_UNITS-1:0] unit_req_i,
   output logic [NUM_UNITS-1:0] grp_en_o,
   output logic                 irq_o
);

   logic [NUM_UNITS-1:0] grp_en_q;
   logic                 irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         grp_en_q <= '0;
      else if (grp_wr_i)
         grp_en_q <= grp_wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else
         irq_q <= |(unit_req_i & grp_en_q);
   end

   assign grp_en_o = grp_en_q;
   assign irq_o    = irq_q;

   // R7
   grp_all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_en_q == '0) |=> !irq_o);

   // R8
   irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((unit_req_i & grp_en_q) != '0) |=> irq_o);

endmodule

// File: rtl/err_status_irq_agg.sv
module err_status_irq_agg
   import err_agg_pkg::*;
#(
   parameter int NUM_UNITS = 3,
   parameter int STAT_W    = 8,
   localparam int IDX_BITS = $clog2(NUM_UNITS + 1),
   localparam int ADDR_W   = IDX_BITS + SEL_BITS,
   localparam int HW_W     = NUM_UNITS * STAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [STAT_W-1:0] reg_wdata,
   output logic [STAT_W-1:0] reg_rdata,
   input  logic [HW_W-1:0]   hw_err,
   output logic              irq_req
);

   localparam logic [IDX_BITS-1:0] GRP_IDX = IDX_BITS'(NUM_UNITS);

   if (NUM_UNITS < 1) begin : g_bad_units
      $error("NUM_UNITS must be at least 1");
   end
   if (STAT_W < NUM_UNITS) begin : g_bad_width
      $error("STAT_W must hold one group bit per unit");
   end

   logic [IDX_BITS-1:0]  unit_idx;
   reg_sel_e             sel;
   logic [NUM_UNITS-1:0] unit_wr;
   logic [NUM_UNITS-1:0] unit_req;
   logic [NUM_UNITS-1:0] grp_en;
   logic                 grp_wr;
   logic [STAT_W-1:0]    view   [NUM_UNITS];
   logic [STAT_W-1:0]    forced [NUM_UNITS];
   logic [STAT_W-1:0]    enab   [NUM_UNITS];

   assign unit_idx = reg_addr[ADDR_W-1:SEL_BITS];
   assign sel      = reg_sel_e'(reg_addr[SEL_BITS-1:0]);
   assign grp_wr   = reg_wr_en && unit_idx == GRP_IDX && sel == SEL_STATUS;

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      assign unit_wr[u] = reg_wr_en && unit_idx == IDX_BITS'(u);

      err_unit #(.STAT_W(STAT_W)) i_unit (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_i     (unit_wr[u]),
         .sel_i    (sel),
         .wdata_i  (reg_wdata),
         .hw_err_i (hw_err[u*STAT_W +: STAT_W]),
         .view_o   (view[u]),
         .force_o  (forced[u]),
         .enable_o (enab[u]),
         .req_o    (unit_req[u])
      );
   end

   err_group_gate #(.NUM_UNITS(NUM_UNITS)) i_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .grp_wr_i    (grp_wr),
      .grp_wdata_i (reg_wdata[NUM_UNITS-1:0]),
      .unit_req_i  (unit_req),
      .grp_en_o    (grp_en),
      .irq_o       (irq_req)
   );

   always_comb begin
      reg_rdata = '0;
      for (int u = 0; u < NUM_UNITS; u++) begin
         if (unit_idx == IDX_BITS'(u)) begin
            case (sel)
               SEL_STATUS: reg_rdata = view[u];
               SEL_FORCE:  reg_rdata = forced[u];
               SEL_ENABLE: reg_rdata = enab[u];
               default:    reg_rdata = '0;
            endcase
         end
      end
      if (unit_idx == GRP_IDX && sel == SEL_STATUS)
         reg_rdata[NUM_UNITS-1:0] = grp_en;
   end

   // R10
   single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grp_wr, unit_wr}));

   // R8
   quiet_units_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_req == '0) |=> !irq_req);

endmodule

// File: tb/test_err_status_irq_agg.sv
module test_err_status_irq_agg;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [23:0] hw_err = '0;
   logic        irq_req;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   err_status_irq_agg i_err_status_irq_agg (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr_en (reg_wr_en),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .hw_err    (hw_err),
      .irq_req   (irq_req)
   );

   // {wr, waddr, wdata, hw, raddr, exp_rdata, exp_irq, req}
   localparam int NV = 22;
   localparam logic [53:0] VEC [NV] = '{
      {1'b0, 4'h0, 8'h00, 24'h000000, 4'hC, 8'h00, 1'b0, 4'd1},  // R1 group mask idle
      {1'b1, 4'h3, 8'h01, 24'h000000, 4'h3, 8'h01, 1'b0, 4'd9},  // R9 enable xlat
      {1'b1, 4'h7, 8'h02, 24'h000000, 4'h7, 8'h02, 1'b0, 4'd9},  // R9 enable msg
      {1'b1, 4'hB, 8'h80, 24'h000000, 4'hB, 8'h80, 1'b0, 4'd9},  // R9 enable dma
      {1'b1, 4'hC, 8'h07, 24'h000000, 4'hC, 8'h07, 1'b0, 4'd9},  // R9 group open
      {1'b0, 4'h0, 8'h00, 24'h000200, 4'h4, 8'h02, 1'b1, 4'd2},  // R2 R8 msg pulse
      {1'b0, 4'h0, 8'h00, 24'h000010, 4'h0, 8'h10, 1'b1, 4'd2},  // R2 xlat pulse
      {1'b1, 4'h6, 8'hFF, 24'h000000, 4'h4, 8'h00, 1'b0, 4'd3},  // R3 clear msg
      {1'b0, 4'h0, 8'h00, 24'h000000, 4'h0, 8'h10, 1'b0, 4'd6},  // R6 bit not enabled
      {1'b1, 4'h9, 8'h80, 24'h000000, 4'h8, 8'h80, 1'b1, 4'd4},  // R4 force dma
      {1'b1, 4'hA, 8'hFF, 24'h000000, 4'h8, 8'h80, 1'b1, 4'd5},  // R5 clear keeps force
      {1'b1, 4'h9, 8'h00, 24'h000000, 4'h8, 8'h00, 1'b0, 4'd4},  // R4 unforce
      {1'b1, 4'hC, 8'h03, 24'h000000, 4'hC, 8'h03, 1'b0, 4'd7},  // R7 mask dma
      {1'b1, 4'h9, 8'h80, 24'h000000, 4'h9, 8'h80, 1'b0, 4'd7},  // R7 forced but masked
      {1'b1, 4'hC, 8'h04, 24'h000000, 4'hC, 8'h04, 1'b1, 4'd7},  // R7 only dma open
      {1'b0, 4'h0, 8'h00, 24'h000200, 4'h4, 8'h02, 1'b1, 4'd7},  // R7 msg latched, masked
      {1'b1, 4'h9, 8'h00, 24'h000000, 4'h8, 8'h00, 1'b0, 4'd7},  // R7 dma drops
      {1'b1, 4'hC, 8'h02, 24'h000000, 4'hC, 8'h02, 1'b1, 4'd7},  // R7 msg open again
      {1'b1, 4'h4, 8'h00, 24'h000000, 4'h4, 8'h02, 1'b1, 4'd9},  // R9 status write ignored
      {1'b0, 4'h0, 8'h00, 24'h000000, 4'h6, 8'h00, 1'b1, 4'd9},  // R9 clear reads zero
      {1'b1, 4'h2, 8'hFF, 24'h000000, 4'h4, 8'h02, 1'b1, 4'd10}, // R10 msg untouched
      {1'b0, 4'h0, 8'h00, 24'h000000, 4'h0, 8'h00, 1'b1, 4'd3}   // R3 xlat cleared
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic wr, input logic [3:0] waddr, input logic [7:0] wdata,
                       input logic [23:0] hw, input logic [3:0] raddr);
      @(negedge clk);
      reg_wr_en = wr; reg_addr = waddr; reg_wdata = wdata; hw_err = hw;
      @(negedge clk);
      reg_wr_en = 1'b0; hw_err = '0; reg_addr = raddr;
      @(negedge clk);
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      reg_addr = a;
      #1 check(req, reg_rdata, exp);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 irq", {7'd0, irq_req}, 8'h00);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][53], VEC[i][52:49], VEC[i][48:41], VEC[i][40:17], VEC[i][16:13]);
         check($sformatf("R%0d rdata row %0d", VEC[i][3:0], i), reg_rdata, VEC[i][12:5]);
         check($sformatf("R%0d irq row %0d", VEC[i][3:0], i), {7'd0, irq_req}, {7'd0, VEC[i][4]});
      end

      // R3 pulse and clear in the same cycle: set wins
      step(1'b1, 4'h2, 8'h10, 24'h000010, 4'h0);
      check("R3 set over clear", reg_rdata, 8'h10);

      // R8 one-cycle latency from a fresh pulse
      step(1'b1, 4'h2, 8'hFF, 24'h0, 4'h0);
      step(1'b1, 4'h6, 8'hFF, 24'h0, 4'h0);
      step(1'b1, 4'hC, 8'h01, 24'h0, 4'hC);
      check("R8 idle", {7'd0, irq_req}, 8'h00);
      @(negedge clk);
      hw_err = 24'h000001;
      @(negedge clk);
      hw_err = '0;
      check("R8 not yet", {7'd0, irq_req}, 8'h00);
      @(negedge clk);
      check("R8 raised", {7'd0, irq_req}, 8'h01);

      // R9 unused address
      step(1'b1, 4'hD, 8'hFF, 24'h0, 4'hD);
      check("R9 unused reads zero", reg_rdata, 8'h00);
      rd(4'hC, 8'h01, "R9 group unchanged");
      step(1'b1, 4'hC, 8'hF9, 24'h0, 4'hC);
      check("R9 unused group bits", reg_rdata, 8'h01);

      // R1 reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check("R1 irq after reset", {7'd0, irq_req}, 8'h00);
      rd(4'h0, 8'h00, "R1 status");
      rd(4'h3, 8'h00, "R1 enable");
      rd(4'hC, 8'h00, "R1 group");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule